// File: doc/BRIEF.md
# Priority-Encoded Set-State Sequencer

This block is a state register for a synchronous controller with up to eight states. It moves only when a request asks it to. Each target state has its own active-low request line. A priority encoder turns the active requests into a binary state code, and the lowest-numbered active request wins. If no request is active, the register holds its value. A decoder turns the held code into one active-low line per state, and the binary code is also driven out for status display. A synchronous clear puts the register back in state 0.

Request lines come from two places, and their active levels are combined:
- External requests: any outside logic can pull one of these low.
- Built-in gating for a sample sequence:
  - An idle state leaves when a command arrives.
  - The next state branches on an internal flag. State 3 is the default branch, and it needs no explicit term because of the priority.
  - One state waits for a subprocess acknowledge.
  - One state sets the flag and returns.
  - One state waits for a condition.
  - A final state clears the flag and waits for a done signal before going back to idle.

Top module: `setstate_seq`

## Requirements
- R1: Exactly one bit of `state_n` is low at any time: bit k is low when the current state is k.
- R2: When several requests are active in one cycle, the next state is the lowest-numbered one. `ext_req_n[k]` low requests state k.
- R3: When no request is active, a clock edge leaves the state and the flag unchanged.
- R4: `clear` high at a clock edge gives state 0 and flag 0, whatever requests are active.
- R5: In state 0 with `cmd` high, the next state is 1.
- R6: In state 1, the next state is 2 if the flag is set, and 3 otherwise.
- R7: State 3 holds until `ack` is high and then moves to 4. State 4 moves to 1 after one cycle and sets the flag on that edge.
- R8: State 2 holds until `cond` is high and then moves to 5. Each edge in state 5 clears the flag. State 5 moves to 0 when `done` is high.
- R9: `state_code` is the current state number in unsigned binary, and every state 0..7 can be reached by request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Synchronous clear to state 0, active high |
| ext_req_n | input | 8 | External set-state requests, active low, bit k targets state k |
| cmd | input | 1 | Start command for the sample sequence |
| ack | input | 1 | Subprocess acknowledge |
| cond | input | 1 | Branch condition that leaves state 2 |
| done | input | 1 | Completion that leaves state 5 |
| state_n | output | 8 | Active-low one-hot state lines |
| state_code | output | 3 | Binary state number |
| flag_a | output | 1 | Internal branch flag |

## Verification
The bench drives the register with simultaneous requests, such as states 4 and 7 together, or a built-in default plus an external higher number. A reversed priority or a missing default would land in the wrong state.

It holds the machine in its wait states with the handshakes low and then with no request at all. A design that reloads on every edge would fall back toward state 0.

It checks the flag around the loop through state 4. A flag set one edge late would send state 1 to 3 a second time.

It asserts clear while requests are active, and while the flag is set, to show that the clear overrides both.

// File: rtl/setstate_seq.sv
module setstate_seq #(
  parameter int NST = 8,
  localparam int CW = $clog2(NST)
) (
  input  logic           clk,
  input  logic           clear,
  input  logic [NST-1:0] ext_req_n,
  input  logic           cmd,
  input  logic           ack,
  input  logic           cond,
  input  logic           done,
  output logic [NST-1:0] state_n,
  output logic [CW-1:0]  state_code,
  output logic           flag_a
);

  logic [CW-1:0]  cur, nxt;
  logic [NST-1:0] st, req, seq_req;
  logic           any_req;

  always_comb begin
    st = '0;
    for (int i = 0; i < NST; i++) st[i] = (cur == CW'(i));
  end

  always_comb begin
    seq_req    = '0;
    seq_req[1] = (st[0] & cmd) | st[4];
    seq_req[2] = st[1] & flag_a;
    seq_req[3] = st[1];
    seq_req[4] = st[3] & ack;
    seq_req[5] = st[2] & cond;
    seq_req[0] = st[5] & done;
  end

  assign req     = ~ext_req_n | seq_req;
  assign any_req = |req;

  always_comb begin
    nxt = cur;
    for (int i = NST - 1; i >= 0; i--)
      if (req[i]) nxt = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (clear)        cur <= '0;
    else if (any_req) cur <= nxt;
  end

  always_ff @(posedge clk) begin
    if (clear)      flag_a <= 1'b0;
    else if (st[4]) flag_a <= 1'b1;
    else if (st[5]) flag_a <= 1'b0;
  end

  assign state_n    = ~st;
  assign state_code = cur;

  // R1
  onehot_out_chk: assert property (@(posedge clk) disable iff (clear)
    $countones(~state_n) == 1);

  // R2
  zero_wins_chk: assert property (@(posedge clk) disable iff (clear)
    !ext_req_n[0] |=> state_code == '0);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (clear)
    (!any_req && !st[4] && !st[5]) |=> ($stable(state_code) && $stable(flag_a)));

  // R6
  default_branch_chk: assert property (@(posedge clk) disable iff (clear)
    (cur == CW'(1) && !flag_a && (&ext_req_n[2:0])) |=> state_code == CW'(3));

  // R7
  return_chk: assert property (@(posedge clk) disable iff (clear)
    (cur == CW'(4) && ext_req_n[0]) |=> (state_code == CW'(1) && flag_a));

  // R8
  flag_clr_chk: assert property (@(posedge clk) disable iff (clear)
    st[5] |=> !flag_a);

endmodule

// File: tb/setstate_seq_bench.sv
module setstate_seq_bench;
  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic [7:0] ext_req_n = 8'hFF;
  logic       cmd = 1'b0, ack = 1'b0, cond = 1'b0, done = 1'b0;
  logic [7:0] state_n;
  logic [2:0] state_code;
  logic       flag_a;

  typedef struct {
    int    code;
    bit    flag;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  setstate_seq u_setstate_seq (
    .clk(clk), .clear(clear), .ext_req_n(ext_req_n), .cmd(cmd), .ack(ack),
    .cond(cond), .done(done), .state_n(state_n), .state_code(state_code),
    .flag_a(flag_a)
  );

  task automatic step(input bit c_clr, input logic [7:0] ext, input bit c_cmd,
                      input bit c_ack, input bit c_cond, input bit c_done,
                      input int ec, input bit ef, input string tag);
    exp_t e;
    @(negedge clk);
    clear = c_clr; ext_req_n = ext; cmd = c_cmd; ack = c_ack;
    cond = c_cond; done = c_done;
    e.code = ec; e.flag = ef; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [7:0] exp_n;
        e = q.pop_front();
        exp_n = ~(8'b1 << e.code);
        n_cmp++;
        if (state_code !== 3'(e.code) || flag_a !== e.flag) begin
          n_bad++;
          $display("FAIL %s: code=%0d flag=%0b expected code=%0d flag=%0b",
                   e.tag, state_code, flag_a, e.code, e.flag);
        end
        n_cmp++;
        if (state_n !== exp_n) begin
          n_bad++;
          $display("FAIL R1: state_n=%b expected %b", state_n, exp_n);
        end
      end
    end
  end

  initial begin
    step(1, 8'hFF, 0,0,0,0, 0, 0, "R4 reset");
    step(0, 8'hFF, 0,0,0,0, 0, 0, "R3 idle hold");
    step(0, 8'hFF, 1,0,0,0, 1, 0, "R5 cmd");
    step(0, 8'hFF, 0,0,0,0, 3, 0, "R6 default branch");
    step(0, 8'hFF, 0,0,0,0, 3, 0, "R7 wait ack");
    step(0, 8'hFF, 0,1,0,0, 4, 0, "R7 ack");
    step(0, 8'hFF, 0,0,0,0, 1, 1, "R7 return sets flag");
    step(0, 8'hFF, 0,0,0,0, 2, 1, "R6 flag branch");
    step(0, 8'hFF, 0,0,0,0, 2, 1, "R8 wait cond");
    step(0, 8'hFF, 0,0,1,0, 5, 1, "R8 cond");
    step(0, 8'hFF, 0,0,0,0, 5, 0, "R8 flag clear");
    step(0, 8'hFF, 0,0,0,1, 0, 0, "R8 done");
    step(0, 8'h6F, 0,0,0,0, 4, 0, "R2 lowest of 4,7");
    step(0, 8'hFF, 0,0,0,0, 1, 1, "R7 state4 return");
    step(0, 8'h7F, 0,0,0,0, 2, 1, "R2 seq 2 over ext 7");
    step(0, 8'hDF, 0,0,0,0, 5, 1, "R9 ext to 5");
    step(0, 8'hFE, 0,0,0,0, 0, 0, "R2 ext 0");
    step(1, 8'hFF, 1,0,0,0, 0, 0, "R4 clear over cmd");
    step(0, 8'hFF, 1,0,0,0, 1, 0, "R5 cmd again");
    step(0, 8'hBF, 0,0,0,0, 3, 0, "R2 default 3 over ext 6");
    step(0, 8'hBF, 0,0,0,0, 6, 0, "R9 ext to 6");
    step(0, 8'hFF, 0,0,0,0, 6, 0, "R3 hold in 6");
    step(0, 8'h7F, 0,0,0,0, 7, 0, "R9 ext to 7");
    step(0, 8'hEF, 0,0,0,0, 4, 0, "R9 ext to 4");
    step(0, 8'hFF, 0,0,0,0, 1, 1, "R7 flag set");
    step(1, 8'hFF, 0,0,0,0, 0, 0, "R4 clear drops flag");
    step(0, 8'hFF, 0,0,0,0, 0, 0, "R3 idle after clear");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule